// File: doc/BRIEF.md
# Programmable Interval Timer with Fast and Slow Tick Sources

This block is a single countdown timer that sits on a 32-bit register bus. A peripheral set instantiates it once for each timer it needs. Software loads a reload value, then sets an enable bit in the control register. The timer then measures one interval. In fast mode the interval is the reload value counted in system clock cycles. In slow mode the interval is exactly one pulse of an external slow-tick strobe, and the reload value plays no part.

When the interval ends, the timer raises a sticky interrupt request. Software clears that request by writing to an acknowledge register. In periodic mode the timer re-arms itself with the same interval after each expiry. In one-shot mode it stops after the first expiry. A live read-only register shows the down-counter.

Rewrites that leave a register unchanged are harmless: they do not disturb an interval in progress. Clock generation for the slow strobe and interrupt masking belong to neighbouring logic.

Top module: `interval_timer`

## Requirements
- R1: After reset, the reload (offset 0x0), current-value (offset 0x4) and control (offset 0x8) registers all read 0, `irq` is low and the timer is stopped.
- R2: Reads of offsets 0x0 and 0x8 return the last values written there. Writes to the current-value offset 0x4 have no effect. The acknowledge offset 0xC reads 0.
- R3: Control bit 7 is the enable. Changing it from 0 to 1 arms a new interval. Changing it from 1 to 0 cancels the interval in progress: the current value reads 0 and no interrupt follows.
- R4: With control bit 3 clear (fast mode), `irq` rises exactly N rising clock edges after the arming write edge, where N is the reload value and 0 behaves as 1. Right after arming, the current value reads N, and it then falls by one each cycle.
- R5: With control bit 3 set (slow mode), the interval ends on the first clock edge after arming at which `slow_tick` is high. The reload value is ignored, and the current value reads 1 while the timer waits.
- R6: With control bit 6 clear (one-shot), the timer stops after its expiry and the current value reads 0.
- R7: With control bit 6 set (periodic), the timer re-arms on each expiry with the same interval, so expiries follow one another every N cycles.
- R8: While enabled, a reload write with a value different from the stored one restarts the countdown from the new value. A write of the same value leaves the countdown untouched.
- R9: A control write that changes only bit 6 keeps the remaining count of the running interval. The new mode applies at that interval's expiry.
- R10: `irq` is sticky: it stays high until any write to offset 0xC, which clears it.
- R11: If an expiry and an acknowledge write fall in the same cycle, `irq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; fast-mode intervals count its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle enable strobe from the slow time base |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Sticky interval-expired request |

## Verification
The assertions assume that every write lasts exactly one cycle and that the offset is stable while `bus_wr` is high. They also assume that `slow_tick` only matters in slow mode, and that no write arrives in the cycles whose countdown step they check. The stimulus drives all bus inputs on falling edges through a single write task that holds the strobe for one cycle. It pulses `slow_tick` for one cycle at a time. Each step check is guarded by `!bus_wr`, so it only applies to quiet cycles, and the sweeps leave long quiet stretches between writes.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_tick,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);

  localparam logic [AW-1:0] OFS_LOAD = AW'(0);
  localparam logic [AW-1:0] OFS_VAL  = AW'(4);
  localparam logic [AW-1:0] OFS_CTRL = AW'(8);
  localparam logic [AW-1:0] OFS_ACK  = AW'(12);
  localparam int B_EN   = 7;
  localparam int B_PER  = 6;
  localparam int B_SLOW = 3;

  logic [DW-1:0] load_q, ctrl_q, cnt_q;
  logic          run_q;

  wire wr_load = bus_wr && (bus_addr == OFS_LOAD);
  wire wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  wire wr_ack  = bus_wr && (bus_addr == OFS_ACK);

  wire [DW-1:0] load_n = wr_load ? bus_wdata : load_q;
  wire [DW-1:0] ctrl_n = wr_ctrl ? bus_wdata : ctrl_q;

  wire en_rise = wr_ctrl && bus_wdata[B_EN] && !ctrl_q[B_EN];
  wire en_fall = wr_ctrl && !bus_wdata[B_EN] && ctrl_q[B_EN];
  wire restart = en_rise || (wr_load && (bus_wdata != load_q) && ctrl_q[B_EN]);

  wire [DW-1:0] interval = ctrl_n[B_SLOW] ? DW'(1) : load_n;
  wire          step     = run_q && (ctrl_n[B_SLOW] ? slow_tick : 1'b1);
  wire          expire   = step && !restart && !en_fall && (cnt_q <= DW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      ctrl_q <= '0;
    end else begin
      load_q <= load_n;
      ctrl_q <= ctrl_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (en_fall) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (restart) begin
      run_q <= 1'b1;
      cnt_q <= interval;
    end else if (expire) begin
      run_q <= ctrl_n[B_PER];
      cnt_q <= ctrl_n[B_PER] ? interval : '0;
    end else if (step) begin
      cnt_q <= cnt_q - DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= expire || (irq && !wr_ack);
  end

  always_comb begin
    case (bus_addr)
      OFS_LOAD: bus_rdata = load_q;
      OFS_VAL:  bus_rdata = cnt_q;
      OFS_CTRL: bus_rdata = ctrl_q;
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slow_tick,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          irq,
  input logic          run_q,
  input logic [DW-1:0] cnt_q,
  input logic [DW-1:0] load_q,
  input logic [DW-1:0] ctrl_q
);

  // R2
  load_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(0)) |=> (load_q == $past(bus_wdata)));

  // R3
  disable_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(8) && !bus_wdata[7]) |=> (!run_q && cnt_q == '0 && !$rose(irq)));

  // R4
  fast_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !ctrl_q[3] && cnt_q > DW'(1) && !bus_wr) |=> (cnt_q == $past(cnt_q) - DW'(1)));

  // R5
  slow_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && ctrl_q[3] && !slow_tick && !bus_wr) |=> !$rose(irq));

  // R6
  stopped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (cnt_q == '0));

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(bus_wr && bus_addr == AW'(12))) |=> irq);

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(12) && !run_q) |=> !irq);

endmodule

bind interval_timer interval_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq),
  .run_q(run_q), .cnt_q(cnt_q), .load_q(load_q), .ctrl_q(ctrl_q)
);

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  localparam logic [3:0] A_LOAD = 4'd0, A_VAL = 4'd4, A_CTRL = 4'd8, A_ACK = 4'd12;

  logic clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0, bus_wr = 1'b0, irq;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int edges = 0, checks = 0, fails = 0;

  interval_timer dut (.clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #10 clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  always @(posedge clk) if (edges > 150000) begin
    fails++; checks++;
    $display("FAIL watchdog: actual %0d edges expected below 150000", edges);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_irq(output int at);
    int g = 0;
    while (!irq && g < 2000) begin @(negedge clk); g++; end
    at = edges;
  endtask

  task automatic stop_all();
    wr(A_CTRL, 32'h0);
    wr(A_ACK, 32'h0);
  endtask

  task automatic pulse();
    slow_tick = 1'b1; @(negedge clk); slow_tick = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    int w, at, w2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_LOAD, d); check("R1 load", d, 0);
    rd(A_VAL, d);  check("R1 value", d, 0);
    rd(A_CTRL, d); check("R1 ctrl", d, 0);
    check("R1 irq", irq, 0);

    // R2 readback and ignored writes
    wr(A_LOAD, 32'hCAFE_1234); rd(A_LOAD, d); check("R2 load readback", d, 32'hCAFE_1234);
    wr(A_CTRL, 32'h0000_0048); rd(A_CTRL, d); check("R2 ctrl readback", d, 32'h48);
    wr(A_VAL, 32'd5); rd(A_VAL, d); check("R2 value write ignored", d, 0);
    rd(A_LOAD, d); check("R2 load unchanged", d, 32'hCAFE_1234);
    rd(A_ACK, d); check("R2 ack reads zero", d, 0);
    check("R2 no irq", irq, 0);

    // R4 R6 R10 one-shot fast sweep
    for (int n = 0; n <= 12; n++) begin
      stop_all();
      wr(A_LOAD, n);
      wr(A_CTRL, 32'h80); w = edges;
      rd(A_VAL, d); check("R4 value after arming", d, n);
      wait_irq(at); check("R4 expiry delay", at - w, (n == 0) ? 1 : n);
      repeat (3) @(negedge clk);
      check("R10 sticky", irq, 1);
      rd(A_VAL, d); check("R6 stopped value", d, 0);
      wr(A_ACK, 32'h1); check("R10 cleared", irq, 0);
    end

    // R7 periodic sweep
    for (int n = 2; n <= 7; n++) begin
      stop_all();
      wr(A_LOAD, n);
      wr(A_CTRL, 32'hC0); w = edges;
      for (int k = 1; k <= 3; k++) begin
        wait_irq(at); check("R7 periodic expiry", at - w, k * n);
        wr(A_ACK, 32'h0);
      end
    end

    // R11 expiry and acknowledge in the same cycle
    stop_all();
    wr(A_LOAD, 1); wr(A_CTRL, 32'hC0); @(negedge clk);
    wr(A_ACK, 32'h0); check("R11 expiry wins", irq, 1);

    // R3 disable cancels
    stop_all();
    wr(A_LOAD, 6); wr(A_CTRL, 32'h80); @(negedge clk);
    wr(A_CTRL, 32'h0);
    repeat (20) @(negedge clk);
    check("R3 no irq after cancel", irq, 0);
    rd(A_VAL, d); check("R3 value after cancel", d, 0);

    // R8 same reload value has no effect
    stop_all();
    wr(A_LOAD, 10); wr(A_CTRL, 32'h80); w = edges;
    repeat (2) @(negedge clk);
    wr(A_LOAD, 10);
    wait_irq(at); check("R8 same value keeps count", at - w, 10);

    // R8 different reload value restarts
    stop_all();
    wr(A_LOAD, 10); wr(A_CTRL, 32'h80);
    repeat (2) @(negedge clk);
    wr(A_LOAD, 20); w2 = edges;
    wait_irq(at); check("R8 new value restarts", at - w2, 20);

    // R9 bit 6 change keeps remaining count
    stop_all();
    wr(A_LOAD, 8); wr(A_CTRL, 32'h80); w = edges;
    repeat (2) @(negedge clk);
    wr(A_CTRL, 32'hC0);
    wait_irq(at); check("R9 remaining kept", at - w, 8);
    wr(A_ACK, 32'h0);
    wait_irq(at); check("R9 new period applied", at - w, 16);

    // R5 slow one-shot, reload ignored
    stop_all();
    wr(A_LOAD, 1000); wr(A_CTRL, 32'h88);
    repeat (5) @(negedge clk);
    check("R5 waits for tick", irq, 0);
    rd(A_VAL, d); check("R5 value while waiting", d, 1);
    pulse(); check("R5 expiry on tick", irq, 1);
    rd(A_VAL, d); check("R6 slow one-shot stops", d, 0);

    // R5 R7 slow periodic
    stop_all();
    wr(A_LOAD, 3); wr(A_CTRL, 32'hC8);
    for (int k = 0; k < 3; k++) begin
      repeat (4) @(negedge clk);
      check("R5 periodic wait", irq, 0);
      pulse(); check("R7 slow periodic expiry", irq, 1);
      wr(A_ACK, 32'h0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule